// File: doc/BRIEF.md
# Shared-RAM packet transmit/receive FIFO pair

This block holds two quadlet-wide queues, one outbound toward a serial-bus link layer and one inbound from it. Both are carved out of a single storage array of 1182 words. A configuration write sets how many words each queue gets. The outbound queue occupies the low part of the array and the inbound queue sits directly above it. Every stored word carries a 33rd bit that marks the end of a packet. From that bit the block keeps a per-queue count of complete packets.

A bulk DMA port fills the outbound queue. While at least one whole packet is waiting, the block holds a transmit request toward the link, and the link drains the words. The link pushes whole received packets, header and trailer included, into the inbound queue, and the DMA side reads them out. A host port can push to or pop from either queue. Both read ports are show-ahead: the oldest word is always on the read data lines. A configuration bit selects whether the DMA writes payload only or header plus payload. The block only carries this bit toward the link; it does not change what is stored.

Top module: `pktFifoPair`

## Requirements
- R1: After reset, both queues are empty and hold 591 words each. All sticky flags, the error flag, the transmit request, the packet-available output and the header mode output are 0, and all read data is zero.
- R2: A configuration write is accepted only if both sizes are nonzero and their sum is at most 1182. An accepted write takes the new sizes and header mode, empties both queues, zeroes their packet counts, clears all sticky flags and the error flag, and discards any queue access in the same cycle. A rejected write sets the error flag and changes nothing else.
- R3: Each queue returns words in write order. Its read port shows the oldest word (32 data bits plus the end bit) in the cycle after that word's write edge. A read strobe removes the word at the next edge.
- R4: A queue of size N accepts exactly N words before it reports full. Its storage wraps, so order is kept over any number of passes. The empty flag is 1 exactly when the queue holds no word.
- R5: A write to a full queue is dropped and sets that queue's sticky overflow flag. A read in the same cycle does not make room for that write.
- R6: A read from an empty queue sets that queue's sticky underflow flag, and the read data stays zero.
- R7: The transmit request is 1 exactly while the outbound queue holds at least one word whose end bit is set. It falls in the cycle after that word is read.
- R8: The packet-available output is 1 exactly while the inbound queue holds at least one word whose end bit is set.
- R9: On a shared write or read path, the DMA or link strobe wins over the host. A host write that loses is lost, and a host read that loses removes nothing.
- R10: The host select input picks the queue for host accesses: 0 selects outbound, 1 selects inbound. The host read data shows the head of the selected queue.
- R11: The header mode output equals the mode bit of the last accepted configuration write. Stored words are the same in either mode.
- R12: The two regions never overlap. With sizes summing to exactly 1182, filling the inbound queue leaves the outbound contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgTxSize | input | 11 | Requested outbound queue size in words |
| cfgRxSize | input | 11 | Requested inbound queue size in words |
| cfgHdrAuto | input | 1 | Header mode bit: 1 = DMA writes payload only |
| txWrEn | input | 1 | DMA write strobe, outbound queue |
| txWrData | input | 32 | DMA write word |
| txWrLast | input | 1 | End-of-packet mark for the DMA word |
| txRdEn | input | 1 | Link read strobe, outbound queue |
| txRdData | output | 32 | Outbound head word, zero when empty |
| txRdLast | output | 1 | End mark of the outbound head word |
| txReq | output | 1 | Transmit request toward the link |
| txHdrAuto | output | 1 | Active header mode |
| rxWrEn | input | 1 | Link write strobe, inbound queue |
| rxWrData | input | 32 | Link write word |
| rxWrLast | input | 1 | End-of-packet mark for the link word |
| rxRdEn | input | 1 | DMA read strobe, inbound queue |
| rxRdData | output | 32 | Inbound head word, zero when empty |
| rxRdLast | output | 1 | End mark of the inbound head word |
| rxPktAvail | output | 1 | At least one complete inbound packet |
| hostSel | input | 1 | Host target: 0 outbound, 1 inbound |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write word |
| hostWrLast | input | 1 | End mark for the host word |
| hostRdEn | input | 1 | Host read strobe |
| hostRdData | output | 32 | Head word of the selected queue |
| hostRdLast | output | 1 | End mark of that head word |
| txFull | output | 1 | Outbound queue full |
| txEmpty | output | 1 | Outbound queue empty |
| rxFull | output | 1 | Inbound queue full |
| rxEmpty | output | 1 | Inbound queue empty |
| txOvf | output | 1 | Sticky outbound overflow |
| txUnf | output | 1 | Sticky outbound underflow |
| rxOvf | output | 1 | Sticky inbound overflow |
| rxUnf | output | 1 | Sticky inbound underflow |
| cfgErr | output | 1 | Last configuration write was rejected |

## Verification
The bench targets these corner cases:

- **Size limits.** The sum of exactly 1182 is accepted, 1183 is rejected, and a zero size is rejected. A design with an off-by-one limit check would accept an oversize split, and one that applies rejected sizes would lose queued words.
- **Full queue.** A simultaneous write and read on a full queue must keep the new word out and raise overflow. A design that lets the read make room would accept that word instead.
- **Collisions.** When the DMA and host strobe the same queue, only the DMA word may be stored, and a doubled read must pop only once.
- **Pointer wrap.** Traffic passes many times through tiny regions to expose wrap errors. A region base added wrongly would show the other queue's words, or stale ones.

// File: rtl/pktFifoPkg.sv
package pktFifoPkg;

  localparam bit SEL_TX = 1'b0;
  localparam bit SEL_RX = 1'b1;

  typedef struct packed {
    logic txWe;
    logic txWrHost;
    logic rxWe;
    logic rxWrHost;
    logic txHave;
    logic rxHave;
  } memCtl_t;

endpackage

// File: rtl/pktFifoPtr.sv
module pktFifoPtr #(
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic [SIZE_W-1:0] size,
  input  logic              push,
  input  logic              pushLast,
  input  logic              pop,
  input  logic              popLast,
  output logic [SIZE_W-1:0] wrOff,
  output logic [SIZE_W-1:0] rdOff,
  output logic              full,
  output logic              empty,
  output logic              pushOk,
  output logic              hasPkt,
  output logic              ovf,
  output logic              unf
);
  localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

  logic [SIZE_W-1:0] cnt;
  logic [SIZE_W-1:0] pktCnt;
  logic popOk, pktIn, pktOut;

  assign full   = (cnt == size);
  assign empty  = (cnt == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign pktIn  = pushOk && pushLast;
  assign pktOut = popOk && popLast;
  assign hasPkt = (pktCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrOff  <= '0;
      rdOff  <= '0;
      cnt    <= '0;
      pktCnt <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (clear) begin
      wrOff  <= '0;
      rdOff  <= '0;
      cnt    <= '0;
      pktCnt <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (pushOk) wrOff <= (wrOff == size - ONE) ? '0 : wrOff + ONE;
      if (popOk)  rdOff <= (rdOff == size - ONE) ? '0 : rdOff + ONE;
      case ({pushOk, popOk})
        2'b10:   cnt <= cnt + ONE;
        2'b01:   cnt <= cnt - ONE;
        default: cnt <= cnt;
      endcase
      case ({pktIn, pktOut})
        2'b10:   pktCnt <= pktCnt + ONE;
        2'b01:   pktCnt <= pktCnt - ONE;
        default: pktCnt <= pktCnt;
      endcase
      if (push && full) ovf <= 1'b1;
      if (pop && empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/pktFifoCtrl.sv
module pktFifoCtrl
  import pktFifoPkg::*;
#(
  parameter int TOTAL_DEPTH = 1182,
  parameter int SIZE_W      = 11,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SIZE_W-1:0] cfgTxSize,
  input  logic [SIZE_W-1:0] cfgRxSize,
  input  logic              cfgHdrAuto,
  input  logic              txWrEn,
  input  logic              txWrLast,
  input  logic              txRdEn,
  input  logic              rxWrEn,
  input  logic              rxWrLast,
  input  logic              rxRdEn,
  input  logic              hostSel,
  input  logic              hostWrEn,
  input  logic              hostWrLast,
  input  logic              hostRdEn,
  input  logic              txHeadLast,
  input  logic              rxHeadLast,
  output memCtl_t           memCtl,
  output logic [ADDR_W-1:0] txWaddr,
  output logic [ADDR_W-1:0] rxWaddr,
  output logic [ADDR_W-1:0] txRaddr,
  output logic [ADDR_W-1:0] rxRaddr,
  output logic              txReq,
  output logic              rxPktAvail,
  output logic              txHdrAuto,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              txOvf,
  output logic              txUnf,
  output logic              rxOvf,
  output logic              rxUnf,
  output logic              cfgErr
);
  localparam int SUM_W = SIZE_W + 1;
  localparam logic [SUM_W-1:0]  TOTAL_L = SUM_W'(TOTAL_DEPTH);
  localparam logic [SIZE_W-1:0] TX_DEF  = SIZE_W'(TOTAL_DEPTH / 2);
  localparam logic [SIZE_W-1:0] RX_DEF  = SIZE_W'(TOTAL_DEPTH - TOTAL_DEPTH / 2);

  logic [SIZE_W-1:0] size  [2];
  logic [SIZE_W-1:0] wrOff [2];
  logic [SIZE_W-1:0] rdOff [2];
  logic [1:0] push, pushLast, pop, popLast;
  logic [1:0] full, empty, pushOk, hasPkt, ovf, unf;
  logic [SUM_W-1:0] reqSum;
  logic cfgAccept;

  // configuration check: both regions nonzero and within the shared array
  assign reqSum    = {1'b0, cfgTxSize} + {1'b0, cfgRxSize};
  assign cfgAccept = cfgWrEn && (cfgTxSize != '0) && (cfgRxSize != '0) && (reqSum <= TOTAL_L);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      size[0]   <= TX_DEF;
      size[1]   <= RX_DEF;
      txHdrAuto <= 1'b0;
      cfgErr    <= 1'b0;
    end else if (cfgAccept) begin
      size[0]   <= cfgTxSize;
      size[1]   <= cfgRxSize;
      txHdrAuto <= cfgHdrAuto;
      cfgErr    <= 1'b0;
    end else if (cfgWrEn) begin
      cfgErr    <= 1'b1;
    end
  end

  // path arbitration: DMA/link strobes win over the host
  assign push[0]     = txWrEn || (hostWrEn && hostSel == SEL_TX);
  assign push[1]     = rxWrEn || (hostWrEn && hostSel == SEL_RX);
  assign pushLast[0] = txWrEn ? txWrLast : hostWrLast;
  assign pushLast[1] = rxWrEn ? rxWrLast : hostWrLast;
  assign pop[0]      = txRdEn || (hostRdEn && hostSel == SEL_TX);
  assign pop[1]      = rxRdEn || (hostRdEn && hostSel == SEL_RX);
  assign popLast[0]  = txHeadLast;
  assign popLast[1]  = rxHeadLast;

  for (genvar i = 0; i < 2; i++) begin : gFifo
    pktFifoPtr #(.SIZE_W(SIZE_W)) uPtr (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (cfgAccept),
      .size     (size[i]),
      .push     (push[i]),
      .pushLast (pushLast[i]),
      .pop      (pop[i]),
      .popLast  (popLast[i]),
      .wrOff    (wrOff[i]),
      .rdOff    (rdOff[i]),
      .full     (full[i]),
      .empty    (empty[i]),
      .pushOk   (pushOk[i]),
      .hasPkt   (hasPkt[i]),
      .ovf      (ovf[i]),
      .unf      (unf[i])
    );
  end

  // outbound region starts at 0, inbound region directly above it
  assign txWaddr = ADDR_W'(wrOff[0]);
  assign txRaddr = ADDR_W'(rdOff[0]);
  assign rxWaddr = ADDR_W'(size[0] + wrOff[1]);
  assign rxRaddr = ADDR_W'(size[0] + rdOff[1]);

  assign memCtl.txWe     = pushOk[0] && !cfgAccept;
  assign memCtl.rxWe     = pushOk[1] && !cfgAccept;
  assign memCtl.txWrHost = !txWrEn;
  assign memCtl.rxWrHost = !rxWrEn;
  assign memCtl.txHave   = !empty[0];
  assign memCtl.rxHave   = !empty[1];

  assign txReq      = hasPkt[0];
  assign rxPktAvail = hasPkt[1];
  assign txFull     = full[0];
  assign txEmpty    = empty[0];
  assign rxFull     = full[1];
  assign rxEmpty    = empty[1];
  assign txOvf      = ovf[0];
  assign txUnf      = unf[0];
  assign rxOvf      = ovf[1];
  assign rxUnf      = unf[1];
endmodule

// File: rtl/pktFifoData.sv
module pktFifoData
  import pktFifoPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TOTAL_DEPTH = 1182,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  memCtl_t           memCtl,
  input  logic [ADDR_W-1:0] txWaddr,
  input  logic [ADDR_W-1:0] rxWaddr,
  input  logic [ADDR_W-1:0] txRaddr,
  input  logic [ADDR_W-1:0] rxRaddr,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txWrLast,
  input  logic [DATA_W-1:0] rxWrData,
  input  logic              rxWrLast,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWrLast,
  input  logic              hostSel,
  output logic [DATA_W-1:0] txRdData,
  output logic              txRdLast,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxRdLast,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostRdLast
);
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] mem [TOTAL_DEPTH];
  logic [WORD_W-1:0] txWord, rxWord, txHead, rxHead, hostHead;

  assign txWord = memCtl.txWrHost ? {hostWrLast, hostWrData} : {txWrLast, txWrData};
  assign rxWord = memCtl.rxWrHost ? {hostWrLast, hostWrData} : {rxWrLast, rxWrData};

  always_ff @(posedge clk) begin
    if (memCtl.txWe) mem[txWaddr] <= txWord;
    if (memCtl.rxWe) mem[rxWaddr] <= rxWord;
  end

  assign txHead   = memCtl.txHave ? mem[txRaddr] : '0;
  assign rxHead   = memCtl.rxHave ? mem[rxRaddr] : '0;
  assign hostHead = (hostSel == SEL_RX) ? rxHead : txHead;

  assign {txRdLast, txRdData}     = txHead;
  assign {rxRdLast, rxRdData}     = rxHead;
  assign {hostRdLast, hostRdData} = hostHead;
endmodule

// File: rtl/pktFifoPair.sv
module pktFifoPair
  import pktFifoPkg::*;
#(
  parameter int  DATA_W      = 32,
  parameter int  TOTAL_DEPTH = 1182,
  localparam int SIZE_W      = $clog2(TOTAL_DEPTH + 1),
  localparam int ADDR_W      = $clog2(TOTAL_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SIZE_W-1:0] cfgTxSize,
  input  logic [SIZE_W-1:0] cfgRxSize,
  input  logic              cfgHdrAuto,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txWrLast,
  input  logic              txRdEn,
  output logic [DATA_W-1:0] txRdData,
  output logic              txRdLast,
  output logic              txReq,
  output logic              txHdrAuto,
  input  logic              rxWrEn,
  input  logic [DATA_W-1:0] rxWrData,
  input  logic              rxWrLast,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxRdData,
  output logic              rxRdLast,
  output logic              rxPktAvail,
  input  logic              hostSel,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostWrLast,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostRdLast,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              txOvf,
  output logic              txUnf,
  output logic              rxOvf,
  output logic              rxUnf,
  output logic              cfgErr
);
  memCtl_t memCtl;
  logic [ADDR_W-1:0] txWaddr, rxWaddr, txRaddr, rxRaddr;

  pktFifoCtrl #(.TOTAL_DEPTH(TOTAL_DEPTH), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk, .rstN, .cfgWrEn, .cfgTxSize, .cfgRxSize, .cfgHdrAuto,
    .txWrEn, .txWrLast, .txRdEn, .rxWrEn, .rxWrLast, .rxRdEn,
    .hostSel, .hostWrEn, .hostWrLast, .hostRdEn,
    .txHeadLast (txRdLast),
    .rxHeadLast (rxRdLast),
    .memCtl, .txWaddr, .rxWaddr, .txRaddr, .rxRaddr,
    .txReq, .rxPktAvail, .txHdrAuto,
    .txFull, .txEmpty, .rxFull, .rxEmpty,
    .txOvf, .txUnf, .rxOvf, .rxUnf, .cfgErr
  );

  pktFifoData #(.DATA_W(DATA_W), .TOTAL_DEPTH(TOTAL_DEPTH), .ADDR_W(ADDR_W)) uData (
    .clk, .memCtl, .txWaddr, .rxWaddr, .txRaddr, .rxRaddr,
    .txWrData, .txWrLast, .rxWrData, .rxWrLast, .hostWrData, .hostWrLast, .hostSel,
    .txRdData, .txRdLast, .rxRdData, .rxRdLast, .hostRdData, .hostRdLast
  );
endmodule

// File: rtl/pktFifoPairChk.sv
module pktFifoPairChk #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [SIZE_W-1:0] cfgTxSize,
  input logic              txWrEn,
  input logic [DATA_W-1:0] txRdData,
  input logic              txRdLast,
  input logic              txReq,
  input logic              rxRdEn,
  input logic              rxPktAvail,
  input logic              txFull,
  input logic              txEmpty,
  input logic              rxEmpty,
  input logic              txOvf,
  input logic              rxUnf,
  input logic              cfgErr
);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty));

  assert_req_has_words_R7: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> !txEmpty);

  assert_avail_has_words_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxPktAvail |-> !rxEmpty);

  assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> (txRdData == '0 && !txRdLast));

  assert_no_room_when_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && txFull && !cfgWrEn) |=> txOvf);

  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txOvf && !cfgWrEn) |=> txOvf);

  assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && rxEmpty && !cfgWrEn) |=> rxUnf);

  assert_zero_size_rejected_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgTxSize == '0) |=> cfgErr);
endmodule

bind pktFifoPair pktFifoPairChk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/sim_pktFifoPair.sv
`timescale 1ns/1ps
module sim_pktFifoPair;
  localparam int SW = 11;
  localparam int TOTAL = 1182;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgHdrAuto = 0;
  logic [SW-1:0] cfgTxSize = '0, cfgRxSize = '0;
  logic txWrEn = 0, txWrLast = 0, txRdEn = 0;
  logic [31:0] txWrData = '0;
  logic rxWrEn = 0, rxWrLast = 0, rxRdEn = 0;
  logic [31:0] rxWrData = '0;
  logic hostSel = 0, hostWrEn = 0, hostWrLast = 0, hostRdEn = 0;
  logic [31:0] hostWrData = '0;
  logic [31:0] txRdData, rxRdData, hostRdData;
  logic txRdLast, rxRdLast, hostRdLast, txReq, txHdrAuto, rxPktAvail;
  logic txFull, txEmpty, rxFull, rxEmpty, txOvf, txUnf, rxOvf, rxUnf, cfgErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pktFifoPair u0 (.*);

  // ---------------- reference model ----------------
  logic [32:0] mTx[$];
  logic [32:0] mRx[$];
  int mTxSz, mRxSz;
  bit mTxOvf, mTxUnf, mRxOvf, mRxUnf, mErr, mHdr;

  task automatic modelReset();
    mTx.delete(); mRx.delete();
    mTxSz = TOTAL / 2; mRxSz = TOTAL - TOTAL / 2;
    mTxOvf = 0; mTxUnf = 0; mRxOvf = 0; mRxUnf = 0; mErr = 0; mHdr = 0;
  endtask

  function automatic bit anyLast(input logic [32:0] q[$]);
    foreach (q[i]) if (q[i][32]) return 1'b1;
    return 1'b0;
  endfunction

  initial modelReset();

  always @(posedge clk) begin
    bit acc, tPush, tPop, rPush, rPop, tFull, tEmpty, rFull, rEmpty;
    logic [32:0] tVal, rVal;
    if (!rstN) modelReset();
    else begin
      acc = 0;
      if (cfgWrEn) begin
        if (cfgTxSize != 0 && cfgRxSize != 0 && int'(cfgTxSize) + int'(cfgRxSize) <= TOTAL) begin
          acc = 1; mTxSz = int'(cfgTxSize); mRxSz = int'(cfgRxSize); mHdr = cfgHdrAuto;
          mTx.delete(); mRx.delete();
          mTxOvf = 0; mTxUnf = 0; mRxOvf = 0; mRxUnf = 0; mErr = 0;
        end else mErr = 1;
      end
      if (!acc) begin
        tPush = txWrEn || (hostWrEn && !hostSel);
        rPush = rxWrEn || (hostWrEn && hostSel);
        tPop  = txRdEn || (hostRdEn && !hostSel);
        rPop  = rxRdEn || (hostRdEn && hostSel);
        tVal  = txWrEn ? {txWrLast, txWrData} : {hostWrLast, hostWrData};
        rVal  = rxWrEn ? {rxWrLast, rxWrData} : {hostWrLast, hostWrData};
        tFull = (mTx.size() == mTxSz); tEmpty = (mTx.size() == 0);
        rFull = (mRx.size() == mRxSz); rEmpty = (mRx.size() == 0);
        if (tPop) begin if (tEmpty) mTxUnf = 1; else void'(mTx.pop_front()); end
        if (rPop) begin if (rEmpty) mRxUnf = 1; else void'(mRx.pop_front()); end
        if (tPush) begin if (tFull) mTxOvf = 1; else mTx.push_back(tVal); end
        if (rPush) begin if (rFull) mRxOvf = 1; else mRx.push_back(rVal); end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, just before the rising edge
  always begin
    logic [32:0] tH, rH, hH;
    @(negedge clk);
    #9;
    tH = (mTx.size() != 0) ? mTx[0] : '0;
    rH = (mRx.size() != 0) ? mRx[0] : '0;
    hH = hostSel ? rH : tH;
    chk("R3", "txHead", {txRdLast, txRdData}, tH);
    chk("R3", "rxHead", {rxRdLast, rxRdData}, rH);
    chk("R10", "hostHead", {hostRdLast, hostRdData}, hH);
    chk("R4", "txFull", txFull, mTx.size() == mTxSz);
    chk("R4", "txEmpty", txEmpty, mTx.size() == 0);
    chk("R4", "rxFull", rxFull, mRx.size() == mRxSz);
    chk("R4", "rxEmpty", rxEmpty, mRx.size() == 0);
    chk("R5", "txOvf", txOvf, mTxOvf);
    chk("R5", "rxOvf", rxOvf, mRxOvf);
    chk("R6", "txUnf", txUnf, mTxUnf);
    chk("R6", "rxUnf", rxUnf, mRxUnf);
    chk("R7", "txReq", txReq, anyLast(mTx));
    chk("R8", "rxPktAvail", rxPktAvail, anyLast(mRx));
    chk("R2", "cfgErr", cfgErr, mErr);
    chk("R11", "txHdrAuto", txHdrAuto, mHdr);
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    cfgWrEn = 0; txWrEn = 0; txRdEn = 0; rxWrEn = 0; rxRdEn = 0;
    hostWrEn = 0; hostRdEn = 0; hostSel = 0;
    txWrLast = 0; rxWrLast = 0; hostWrLast = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic cfg(input int tx, input int rx, input bit h);
    cfgWrEn = 1; cfgTxSize = SW'(tx); cfgRxSize = SW'(rx); cfgHdrAuto = h; step();
  endtask

  task automatic pushTx(input logic [31:0] d, input bit l);
    txWrEn = 1; txWrData = d; txWrLast = l; step();
  endtask

  task automatic pushRx(input logic [31:0] d, input bit l);
    rxWrEn = 1; rxWrData = d; rxWrLast = l; step();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    chk("R1", "txEmpty", txEmpty, 1);
    chk("R1", "rxEmpty", rxEmpty, 1);
    chk("R1", "txReq", txReq, 0);
    chk("R1", "hdr", txHdrAuto, 0);
    chk("R1", "flags", {txOvf, txUnf, rxOvf, rxUnf, cfgErr}, 0);
    chk("R1", "data", {txRdData, rxRdData}, 0);

    // R1/R4 default split is 591 words each
    for (int i = 0; i < 591; i++) pushTx(32'h1000 + i, (i % 10) == 9);
    chk("R1", "txFull at 591", txFull, 1);
    for (int i = 0; i < 590; i++) pushRx(32'h2000 + i, 0);
    chk("R1", "rxFull at 590", rxFull, 0);
    pushRx(32'h2FFF, 1);
    chk("R1", "rxFull at 591", rxFull, 1);
    pushTx(32'hDEAD, 1);  // R5 overflow
    chk("R5", "txOvf", txOvf, 1);
    for (int i = 0; i < 592; i++) begin txRdEn = 1; step(); end
    chk("R6", "txUnf", txUnf, 1);
    chk("R6", "tx zero", {txRdLast, txRdData}, 0);

    // R2 accept clears flags, R11 mode
    cfg(4, 3, 1);
    chk("R2", "cleared", {txOvf, txUnf, rxEmpty, cfgErr}, 4'b0010);
    chk("R11", "hdr set", txHdrAuto, 1);

    // R9 write collision: host word lost
    txWrEn = 1; txWrData = 32'hA; hostWrEn = 1; hostSel = 0; hostWrData = 32'hB; step();
    pushTx(32'hC, 1);
    chk("R9", "head A", txRdData, 32'hA);
    chk("R7", "req", txReq, 1);
    txRdEn = 1; step();
    chk("R9", "host word dropped", {txRdLast, txRdData}, {1'b1, 32'hC});
    txRdEn = 1; step();
    chk("R7", "req falls", txReq, 0);

    // R9 read collision: one pop only
    pushRx(32'h11, 0);
    pushRx(32'h22, 1);
    rxRdEn = 1; hostRdEn = 1; hostSel = 1; step();
    chk("R9", "single pop", rxRdData, 32'h22);
    chk("R8", "avail", rxPktAvail, 1);

    // R10 host access to inbound queue
    hostWrEn = 1; hostSel = 1; hostWrData = 32'h33; hostWrLast = 1; step();
    hostSel = 1; #1;
    chk("R10", "host head rx", hostRdData, 32'h22);
    hostRdEn = 1; step();
    hostSel = 1; #1;
    chk("R10", "host next rx", hostRdData, 32'h33);
    hostRdEn = 1; step();
    chk("R8", "avail falls", rxPktAvail, 0);

    // R5 full with simultaneous read
    for (int i = 0; i < 4; i++) pushTx(32'h40 + i, i == 3);
    txWrEn = 1; txWrData = 32'h99; txRdEn = 1; step();
    chk("R5", "ovf with read", txOvf, 1);
    chk("R5", "not refilled", txFull, 0);

    // R4 wrap in tiny regions
    cfg(3, 2, 0);
    for (int i = 0; i < 30; i++) begin
      txWrEn = 1; txWrData = 32'h500 + i; txWrLast = i[0];
      rxWrEn = 1; rxWrData = 32'h600 + i; rxWrLast = i[1];
      txRdEn = (i % 3) != 0; rxRdEn = (i % 2) != 0; step();
    end

    // R2 rejections keep contents
    pushTx(32'h77, 1);
    cfg(1000, 183, 1);
    chk("R2", "reject sum", cfgErr, 1);
    chk("R11", "hdr kept", txHdrAuto, 0);
    cfg(0, 5, 1);
    chk("R2", "reject zero", cfgErr, 1);

    // R12 exact fit
    cfg(1000, 182, 0);
    chk("R2", "accept 1182", cfgErr, 0);
    pushTx(32'hAA, 0);
    pushTx(32'hBB, 1);
    for (int i = 0; i < 182; i++) pushRx(32'h3000 + i, i == 181);
    chk("R12", "rx full", rxFull, 1);
    chk("R12", "tx head intact", txRdData, 32'hAA);
    txRdEn = 1; step();
    chk("R12", "tx second intact", txRdData, 32'hBB);

    // mixed traffic
    cfg(5, 3, 0);
    for (int i = 0; i < 3000; i++) begin
      txWrEn = ($urandom_range(0, 2) == 0); txWrData = $urandom(); txWrLast = $urandom_range(0, 1);
      rxWrEn = ($urandom_range(0, 2) == 0); rxWrData = $urandom(); rxWrLast = $urandom_range(0, 1);
      txRdEn = ($urandom_range(0, 2) == 0); rxRdEn = ($urandom_range(0, 2) == 0);
      hostSel = $urandom_range(0, 1); hostWrEn = ($urandom_range(0, 3) == 0);
      hostWrData = $urandom(); hostWrLast = $urandom_range(0, 1);
      hostRdEn = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 199) == 0) begin
        cfgWrEn = 1; cfgTxSize = SW'($urandom_range(0, 7)); cfgRxSize = SW'($urandom_range(0, 7));
        cfgHdrAuto = $urandom_range(0, 1);
      end
      step();
    end

    repeat (2) step();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule